// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the serial front end of a 16-line port expander. It sits on a two-wire I2C bus as a target and gives a host byte-wide access to twenty-two 8-bit control and status registers at offsets 0x00 to 0x15. The register bank itself lives in the neighbouring port and interrupt logic. This block presents a simple strobe interface to it: an offset, write data with a write strobe, and a read strobe with read data returned in the same cycle.

SCL and SDA are oversampled by the system clock. Each line goes through a synchronizer and a three-sample majority filter before START, STOP and clock edges are detected. The target address is 0x10 plus a 5-bit selector taken from board straps. The first byte after an address+write is a command byte that loads the register pointer. The pointer then advances after every data byte.

A read is done as address+write, command byte, repeated START, then address+read. Reading either of the two pin-state registers (offsets 0x00 and 0x01) raises an extra strobe, which the interrupt logic uses to clear pending inputs. The target drives only an open-drain enable for SDA and never stretches SCL.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_oe_o`, `reg_wr_o`, `reg_rd_o` and `state_rd_o` are all low.
- R2: A first byte whose upper seven bits equal 0x10 + `addr_sel_i` is acknowledged by driving SDA low for the ninth clock. Any other address is not acknowledged, and the target ignores every following byte until the next START.
- R3: In a write, the byte after the address sets the register pointer. Each data byte that follows produces one `reg_wr_o` pulse with `reg_wdata_o` equal to the byte (MSB first on the wire) and `reg_addr_o` equal to the pointer, and is acknowledged.
- R4: After each data byte, written or read, the pointer advances by one, and offset 0x15 is followed by 0x00.
- R5: Offsets 0x00, 0x01, 0x0C and 0x0D are read-only. Data bytes aimed at them are acknowledged but cause no write strobe.
- R6: A command byte above 0x15 is acknowledged. Data bytes written there cause no write strobe, and bytes read there are 0x00.
- R7: After a repeated START with address+read, the target shifts out the register at the pointer MSB first, and continues with the next offset while the master acknowledges. A master NACK ends the read and releases SDA. The target changes SDA only while SCL is low.
- R8: `state_rd_o` pulses once for each byte read from offset 0x00 or 0x01, and for no other offset.
- R9: A high pulse of one system clock on SCL during a low phase is rejected and does not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_sel_i | input | 5 | Strap selector added to base address 0x10 |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| reg_addr_o | output | 5 | Current register offset |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe; reg_rdata_i sampled in that cycle |
| reg_rdata_i | input | 8 | Read data for reg_addr_o |
| state_rd_o | output | 1 | Pulses when a pin-state register (offset 0 or 1) is read |

## Verification
The hardest cases to reach from the ports are pointer wrap-around and the reject path of the filter. Wrap-around in a read shows up only as byte order and as the count of state-read strobes, so the bench reads twenty-three bytes in one burst. That burst must return offset 0x00 again and give exactly three state-read pulses. Filter rejection needs a one-cycle SCL pulse placed inside a low phase, after SDA has been set up, so the bench injects it from within the byte-send task. It then checks that the byte still lands intact at the right offset. The address sweep covers all 32 selector values, each with a matching and a non-matching address.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned NUM_REGS  = 22;
  localparam int unsigned PTR_W     = $clog2(NUM_REGS);
  localparam int unsigned SEL_W     = 5;
  localparam logic [6:0]  ADDR_BASE = 7'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WR, ST_ACK, ST_TX, ST_MACK
  } phase_e;

  function automatic logic is_read_only(logic [PTR_W-1:0] p);
    return (p == PTR_W'(0)) || (p == PTR_W'(1)) ||
           (p == PTR_W'(12)) || (p == PTR_W'(13));
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
      line_o <= (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) | (win_q[0] & win_q[2]);
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [6:0]       own_addr_i,
  input  logic [7:0]       rdata_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_wr_o,
  output logic             reg_rd_o
);
  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  phase_e st_q, ret_q;
  logic [7:0] sr_q;
  logic [3:0] cnt_q;
  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic ptr_ok_q, oe_q, mack_q;
  logic byte_done, load_tx;
  logic [7:0] tx_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  assign byte_done = scl_fall && (cnt_q == 4'd8);
  assign load_tx   = scl_fall && (((st_q == ST_ACK) && (ret_q == ST_TX)) ||
                                  ((st_q == ST_MACK) && !mack_q));
  assign tx_byte   = ptr_ok_q ? rdata_i : 8'h00;
  assign ptr_inc   = (ptr_q == PTR_W'(NUM_REGS-1)) ? '0 : ptr_q + 1'b1;

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = sr_q;
  assign reg_wr_o    = (st_q == ST_WR) && byte_done && ptr_ok_q && !is_read_only(ptr_q);
  assign reg_rd_o    = load_tx && ptr_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ret_q    <= ST_IDLE;
      sr_q     <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      ptr_ok_q <= 1'b1;
      oe_q     <= 1'b0;
      mack_q   <= 1'b1;
    end else if (start_det) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sr_q  <= {sr_q[6:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_done) begin
            if (st_q == ST_ADDR) begin
              if (sr_q[7:1] == own_addr_i) begin
                oe_q  <= 1'b1;
                st_q  <= ST_ACK;
                ret_q <= sr_q[0] ? ST_TX : ST_CMD;
              end else begin
                st_q <= ST_IDLE;  // not ours: stay quiet until next START
              end
            end else begin
              if (st_q == ST_CMD) begin
                ptr_q    <= sr_q[PTR_W-1:0];
                ptr_ok_q <= sr_q < 8'(NUM_REGS);
              end else if (ptr_ok_q) begin
                ptr_q <= ptr_inc;
              end
              oe_q  <= 1'b1;
              st_q  <= ST_ACK;
              ret_q <= ST_WR;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (ret_q == ST_TX) begin
              sr_q <= tx_byte;
              oe_q <= ~tx_byte[7];
              st_q <= ST_TX;
              if (ptr_ok_q) ptr_q <= ptr_inc;
            end else begin
              oe_q <= 1'b0;
              st_q <= ret_q;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              sr_q  <= {sr_q[6:0], 1'b0};
              oe_q  <= ~sr_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= sda_i;
          if (scl_fall) begin
            if (!mack_q) begin
              sr_q  <= tx_byte;
              oe_q  <= ~tx_byte[7];
              cnt_q <= '0;
              st_q  <= ST_TX;
              if (ptr_ok_q) ptr_q <= ptr_inc;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] addr_sel_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_wr_o,
  output logic             reg_rd_o,
  input  logic [7:0]       reg_rdata_i,
  output logic             state_rd_o
);
  localparam int unsigned NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw_lines, clean_lines;
  logic [6:0] own_addr;

  assign raw_lines = {sda_i, scl_i};
  assign own_addr  = ADDR_BASE + 7'(addr_sel_i);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  i2c_target_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (clean_lines[0]),
    .sda_i       (clean_lines[1]),
    .own_addr_i  (own_addr),
    .rdata_i     (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o)
  );

  assign state_rd_o = reg_rd_o && (reg_addr_o < PTR_W'(2));
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_reg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             reg_wr_o,
  input logic             reg_rd_o
);
  assert_wr_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_addr_o < PTR_W'(NUM_REGS)) && (reg_addr_o != 5'd0) &&
                 (reg_addr_o != 5'd1) && (reg_addr_o != 5'd12) && (reg_addr_o != 5'd13));

  assert_rd_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> reg_addr_o < PTR_W'(NUM_REGS));

  assert_wr_excl_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !reg_rd_o && !sda_oe_o);

  assert_wr_then_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> sda_oe_o);

  assert_drive_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .reg_addr_o (reg_addr_o),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int Q = 10;
  localparam logic [6:0] SEL_USED = 7'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] sel = '0;
  logic sda_oe, wr, rd, st_rd;
  logic [4:0] raddr;
  logic [7:0] wdata, rdata;
  logic sda_bus;
  logic [7:0] model [32];
  logic [7:0] expv [32];
  int wr_cnt, st_cnt;
  int errs = 0, checks = 0;
  bit done = 0;

  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = (raddr < 5'd22) ? model[raddr] : 8'hEE;

  i2c_reg_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sel), .sda_oe_o(sda_oe), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_wr_o(wr), .reg_rd_o(rd),
    .reg_rdata_i(rdata), .state_rd_o(st_rd)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 5 + 8'h31);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) model[i] <= init_val(i);
      wr_cnt <= 0;
      st_cnt <= 0;
    end else begin
      if (wr) begin
        model[raddr] <= wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (st_rd) st_cnt <= st_cnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch) begin
        w(4); scl_m = 1'b1; w(1); scl_m = 1'b0; w(Q - 5);
      end else begin
        w(Q);
      end
      scl_m = 1'b1; w(2 * Q);
      scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    ack = ~sda_bus;
    w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      scl_m = 1'b1; w(Q);
      b[i] = sda_bus;
      w(Q);
      scl_m = 1'b0;
    end
    w(Q);
    sda_m = nack; w(Q);
    scl_m = 1'b1; w(2 * Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic set_ptr(input logic [7:0] cmd);
    bit a;
    bus_start();
    send({7'h10 + SEL_USED, 1'b0}, 0, a);
    chk("R2 own address ack", 32'(a), 32'd1);
    send(cmd, 0, a);
    chk("R3/R6 command ack", 32'(a), 32'd1);
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    int base, sbase;
    for (int i = 0; i < 32; i++) expv[i] = init_val(i);

    // R1 reset state
    w(5);
    chk("R1 sda_oe in reset", 32'(sda_oe), 0);
    chk("R1 strobes in reset", 32'({wr, rd, st_rd}), 0);
    rst_n = 1'b1; w(10);
    chk("R1 sda_oe after reset", 32'(sda_oe), 0);
    chk("R1 strobes after reset", 32'({wr, rd, st_rd}), 0);

    // R2 selector sweep: own address acked, a foreign one not
    for (int s = 0; s < 32; s++) begin
      sel = 5'(s); w(2);
      bus_start(); send({7'h10 + 7'(s), 1'b0}, 0, a); bus_stop();
      chk("R2 match ack", 32'(a), 32'd1);
      bus_start(); send({(7'h10 + 7'(s)) ^ 7'h20, 1'b0}, 0, a); bus_stop();
      chk("R2 foreign nack", 32'(a), 32'd0);
    end
    sel = 5'(SEL_USED); w(2);

    // R2 foreign address: following bytes ignored
    base = wr_cnt;
    bus_start(); send(8'h7E, 0, a);
    send(8'h03, 0, a); chk("R2 ignored cmd nack", 32'(a), 0);
    send(8'h55, 0, a); chk("R2 ignored data nack", 32'(a), 0);
    bus_stop();
    chk("R2 no write after mismatch", 32'(wr_cnt - base), 0);
    chk("R2 reg3 untouched", 32'(model[3]), 32'(expv[3]));

    // R3/R4/R5 burst write over the whole bank
    base = wr_cnt;
    set_ptr(8'h00);
    for (int i = 0; i < 22; i++) begin
      logic [7:0] v;
      v = 8'(i * 3 + 8'h40);
      send(v, 0, a);
      chk("R5/R3 data ack", 32'(a), 32'd1);
      if (!(i == 0 || i == 1 || i == 12 || i == 13)) expv[i] = v;
    end
    bus_stop();
    chk("R5 write strobe count", 32'(wr_cnt - base), 32'd18);
    for (int i = 0; i < 22; i++) chk("R3/R5 bank contents", 32'(model[i]), 32'(expv[i]));

    // R4 wrap during write: 20,21,0(ro),1(ro),2
    set_ptr(8'd20);
    send(8'hA1, 0, a); send(8'hA2, 0, a); send(8'hA3, 0, a);
    send(8'hA4, 0, a); send(8'hA5, 0, a);
    bus_stop();
    expv[20] = 8'hA1; expv[21] = 8'hA2; expv[2] = 8'hA5;
    chk("R4 wrap write 20", 32'(model[20]), 32'(expv[20]));
    chk("R4 wrap write 21", 32'(model[21]), 32'(expv[21]));
    chk("R5 wrap ro 0", 32'(model[0]), 32'(expv[0]));
    chk("R5 wrap ro 1", 32'(model[1]), 32'(expv[1]));
    chk("R4 wrap write 2", 32'(model[2]), 32'(expv[2]));

    // R7/R4/R8 burst read of 23 bytes wraps back to offset 0
    sbase = st_cnt;
    set_ptr(8'h00);
    bus_rstart();
    send({7'h10 + SEL_USED, 1'b1}, 0, a);
    chk("R7 read address ack", 32'(a), 32'd1);
    for (int i = 0; i < 23; i++) begin
      recv(i == 22, b);
      chk("R7/R4 read data", 32'(b), 32'(expv[i % 22]));
    end
    bus_stop();
    chk("R7 bus released after nack", 32'(sda_oe), 0);
    chk("R8 state read pulses", 32'(st_cnt - sbase), 32'd3);

    // R8 read away from state registers
    sbase = st_cnt;
    set_ptr(8'd12);
    bus_rstart(); send({7'h10 + SEL_USED, 1'b1}, 0, a);
    for (int i = 0; i < 3; i++) begin
      recv(i == 2, b);
      chk("R7 mid read", 32'(b), 32'(expv[12 + i]));
    end
    bus_stop();
    chk("R8 no state pulse", 32'(st_cnt - sbase), 0);

    // R6 out-of-range command
    base = wr_cnt;
    set_ptr(8'h16);
    send(8'h99, 0, a);
    chk("R6 data ack out of range", 32'(a), 32'd1);
    bus_stop();
    chk("R6 no write out of range", 32'(wr_cnt - base), 0);
    set_ptr(8'h80);
    bus_rstart(); send({7'h10 + SEL_USED, 1'b1}, 0, a);
    recv(1, b); bus_stop();
    chk("R6 read zero", 32'(b), 0);

    // R9 glitch on SCL during every low phase of a data byte
    set_ptr(8'd7);
    send(8'h3C, 1, a);
    bus_stop();
    expv[7] = 8'h3C;
    chk("R9 ack with glitches", 32'(a), 32'd1);
    chk("R9 data intact", 32'(model[7]), 32'(expv[7]));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule